// File: doc/BRIEF.md
# Flash Reset Sequencing Controller

This block decides when the command interface of a serial flash device may run and when it must stay shut. It follows two reset paths. A cold reset begins when the supply-good level rises after a long enough low period, then holds the device blocked for a fixed power-up time. A warm reset comes in on the fourth data pin, which doubles as an active-low reset line. That reset is honoured only when the function is enabled and the pin is not carrying data. The pin carries data when quad mode is on and chip select is low.

While either reset is running, `blocked_o` stays high. The surrounding logic uses it to ignore commands and to release its output drivers. When the sequence completes, the block raises `ready_o` for exactly one cycle, on the first cycle of interface standby. All timing values are parameters given in clock cycles, each of at least one. Every input is assumed to be synchronous to `clk` already.

Top module: `flash_rst_seq`

## Requirements
- R1: After the synchronous reset `rst_n` is released, the block is in standby: `blocked_o` = 0 and `ready_o` = 0.
- R2: If `pwr_good_i` is sampled low on at least T_PD consecutive clock edges and is then sampled high, `blocked_o` rises after that edge and stays high for exactly T_PU cycles.
- R3: A low period of `pwr_good_i` that lasts fewer than T_PD edges starts nothing and leaves `blocked_o` low.
- R4: During the power-up period, the reset pin, chip select, quad flag and enable are ignored. The period is neither shortened nor lengthened by them.
- R5: `ready_o` is a one-cycle pulse. It is high exactly on the first cycle in which `blocked_o` is low again after a cold or warm reset, and at no other time.
- R6: The reset pin counts as active when `hw_rst_en_i` = 1, `io3_rst_n_i` = 0, and either `quad_mode_i` = 0 or `cs_n_i` = 1. When it is active on T_RP consecutive edges in standby, `blocked_o` rises after the T_RP-th edge.
- R7: Activity on the pin that is shorter than T_RP consecutive edges is ignored, and so is pin activity while the function is disabled or while quad mode is on with `cs_n_i` = 0. In each case `blocked_o` stays low.
- R8: A warm reset ends at the first edge at which both of the following hold: T_RPH edges have passed since the warm reset began, and the pin has been inactive for T_RH consecutive edges.
- R9: A qualified cold start that arrives during a warm reset takes over. No ready pulse is issued in between, and `blocked_o` then stays high for T_PU more cycles.
- R10: `blocked_o` is high in every cycle in which a reset sequence is in progress, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the controller logic |
| pwr_good_i | input | 1 | Supply-good level, high when the core supply is in range |
| cs_n_i | input | 1 | Chip select, active low |
| io3_rst_n_i | input | 1 | Shared fourth data line / active-low reset pin |
| hw_rst_en_i | input | 1 | Configuration enable for the pin reset function |
| quad_mode_i | input | 1 | Quad mode flag; when set, the pin is data while chip select is low |
| blocked_o | output | 1 | High while a reset sequence runs; gates commands and drivers |
| ready_o | output | 1 | One-cycle pulse when interface standby is entered |

## Verification
The bench targets the edge counts around each threshold. Supply dips of T_PD−1 and T_PD edges must behave differently, and a pin pulse of T_RP−1 edges must not start a warm reset, including when it is immediately followed by a second short pulse. An off-by-one counter would start or miss a reset, or stretch or shorten the blocked window by a cycle.

It holds the pin low past T_RPH to show that the release hold decides the end of the warm reset. A design that checked only one timer would drop `blocked_o` early. It also drives pin activity during the power-up period and in quad mode with chip select low; a wrong qualification would start a spurious warm reset. Finally, it starts a cold reset in the middle of a warm one: a design that gave the warm path priority would emit a stray ready pulse or end too soon.

// File: rtl/flash_rst_pkg.sv
// Package: shared types of the flash reset sequencing controller.
// Assumes: nothing beyond IEEE 1800-2017.
package flash_rst_pkg;

    // Sequencer modes: idle standby, power-up (cold) and pin (warm) reset.
    typedef enum logic [1:0] {
        SEQ_STANDBY = 2'd0,
        SEQ_COLD    = 2'd1,
        SEQ_WARM    = 2'd2
    } seq_state_e;

endpackage

// File: rtl/frs_supply_mon.sv
// Module: frs_supply_mon
// Watches the supply-good level and signals a cold start for one cycle
// when the level rises after a low period of at least PD_CYC edges.
// Assumes: pwr_good_i is already synchronous to clk; PD_CYC >= 1.
module frs_supply_mon #(
    parameter int PD_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    output logic cold_go_o
);

    localparam int LW = $clog2(PD_CYC + 1);
    localparam logic [LW-1:0] LOW_FULL = LW'(PD_CYC);

    logic [LW-1:0] low_cnt;
    logic          pg_q;

    // Count consecutive low samples (saturating) and remember the last level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pg_q    <= 1'b0;
        end else begin
            pg_q <= pwr_good_i;
            if (pwr_good_i) begin
                low_cnt <= '0;
            end else if (low_cnt != LOW_FULL) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    // A rising supply-good level after a long enough low period starts a cold reset.
    always_comb begin
        cold_go_o = pwr_good_i && !pg_q && (low_cnt == LOW_FULL);
    end

endmodule

// File: rtl/frs_warm_qual.sv
// Module: frs_warm_qual
// Qualifies the shared reset pin and asks for a warm reset once the pin has
// been active for RP_CYC consecutive edges while listening is allowed.
// Assumes: all inputs synchronous to clk; RP_CYC >= 1.
module frs_warm_qual #(
    parameter int RP_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_en_i,
    input  logic quad_mode_i,
    input  logic cs_n_i,
    input  logic io3_rst_n_i,
    input  logic listen_i,
    output logic rst_act_o,
    output logic warm_go_o
);

    localparam int RW = $clog2(RP_CYC + 1);
    localparam logic [RW-1:0] RUN_LAST = RW'(RP_CYC - 1);

    logic [RW-1:0] run_cnt;

    // The pin acts as reset only when enabled and not carrying quad data.
    always_comb begin
        rst_act_o = hw_rst_en_i && !io3_rst_n_i && (!quad_mode_i || cs_n_i);
        warm_go_o = listen_i && rst_act_o && (run_cnt == RUN_LAST);
    end

    // Count the run of active samples; any gap or non-listening cycle restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (listen_i && rst_act_o && !warm_go_o) begin
            run_cnt <= run_cnt + 1'b1;
        end else begin
            run_cnt <= '0;
        end
    end

endmodule

// File: rtl/frs_seq_fsm.sv
// Module: frs_seq_fsm
// Holds the sequencer mode and the power-up, warm-process and release-hold
// timers; issues blocked and the one-cycle ready pulse.
// Assumes: cold_go_i has priority over everything; PU/RPH/RH >= 1.
module frs_seq_fsm
    import flash_rst_pkg::*;
#(
    parameter int PU_CYC  = 32,
    parameter int RPH_CYC = 16,
    parameter int RH_CYC  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cold_go_i,
    input  logic warm_go_i,
    input  logic rst_act_i,
    output logic idle_o,
    output logic blocked_o,
    output logic ready_o
);

    localparam int PW = $clog2(PU_CYC + 1);
    localparam int HW = $clog2(RPH_CYC + 1);
    localparam int DW = $clog2(RH_CYC + 1);
    localparam logic [PW-1:0] PU_LAST  = PW'(PU_CYC - 1);
    localparam logic [HW-1:0] RPH_FULL = HW'(RPH_CYC);
    localparam logic [DW-1:0] RH_FULL  = DW'(RH_CYC);

    seq_state_e    state;
    logic [PW-1:0] pu_cnt;
    logic [HW-1:0] rph_cnt;
    logic [DW-1:0] rh_cnt;
    logic [HW-1:0] rph_nxt;
    logic [DW-1:0] rh_nxt;
    logic          warm_done;

    // Next values of the two warm timers: process time saturates, hold restarts on activity.
    always_comb begin
        rph_nxt = (rph_cnt == RPH_FULL) ? rph_cnt : rph_cnt + 1'b1;
        if (rst_act_i) begin
            rh_nxt = '0;
        end else begin
            rh_nxt = (rh_cnt == RH_FULL) ? rh_cnt : rh_cnt + 1'b1;
        end
        warm_done = (rph_nxt == RPH_FULL) && (rh_nxt == RH_FULL);
    end

    // Mode register and timers; a cold start overrides any mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_STANDBY;
            pu_cnt  <= '0;
            rph_cnt <= '0;
            rh_cnt  <= '0;
            ready_o <= 1'b0;
        end else begin
            ready_o <= 1'b0;
            if (cold_go_i) begin
                state   <= SEQ_COLD;
                pu_cnt  <= '0;
                rph_cnt <= '0;
                rh_cnt  <= '0;
            end else begin
                unique case (state)
                    SEQ_STANDBY: begin
                        if (warm_go_i) begin
                            state   <= SEQ_WARM;
                            rph_cnt <= '0;
                            rh_cnt  <= '0;
                        end
                    end
                    SEQ_COLD: begin
                        if (pu_cnt == PU_LAST) begin
                            state   <= SEQ_STANDBY;
                            pu_cnt  <= '0;
                            ready_o <= 1'b1;
                        end else begin
                            pu_cnt <= pu_cnt + 1'b1;
                        end
                    end
                    SEQ_WARM: begin
                        if (warm_done) begin
                            state   <= SEQ_STANDBY;
                            rph_cnt <= '0;
                            rh_cnt  <= '0;
                            ready_o <= 1'b1;
                        end else begin
                            rph_cnt <= rph_nxt;
                            rh_cnt  <= rh_nxt;
                        end
                    end
                    default: begin
                        state <= SEQ_STANDBY;
                    end
                endcase
            end
        end
    end

    // Blocked whenever a sequence is running.
    always_comb begin
        idle_o    = (state == SEQ_STANDBY);
        blocked_o = !idle_o;
    end

endmodule

// File: rtl/flash_rst_seq.sv
// Module: flash_rst_seq (top)
// Sequences cold (supply) and warm (shared pin) resets of a serial flash
// interface, blocking commands and drivers until standby is reached.
// Assumes: inputs synchronous to clk; all timing parameters >= 1 cycle.
module flash_rst_seq #(
    parameter int T_PD  = 16,
    parameter int T_PU  = 32,
    parameter int T_RP  = 8,
    parameter int T_RPH = 16,
    parameter int T_RH  = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good_i,
    input  logic cs_n_i,
    input  logic io3_rst_n_i,
    input  logic hw_rst_en_i,
    input  logic quad_mode_i,
    output logic blocked_o,
    output logic ready_o
);

    logic cold_go;
    logic warm_go;
    logic rst_act;
    logic idle;
    logic listen;

    // The pin is only watched in standby and not when a cold start wins this cycle.
    always_comb begin
        listen = idle && !cold_go;
    end

    frs_supply_mon #(.PD_CYC(T_PD)) u_supply (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good_i (pwr_good_i),
        .cold_go_o  (cold_go)
    );

    frs_warm_qual #(.RP_CYC(T_RP)) u_warm (
        .clk         (clk),
        .rst_n       (rst_n),
        .hw_rst_en_i (hw_rst_en_i),
        .quad_mode_i (quad_mode_i),
        .cs_n_i      (cs_n_i),
        .io3_rst_n_i (io3_rst_n_i),
        .listen_i    (listen),
        .rst_act_o   (rst_act),
        .warm_go_o   (warm_go)
    );

    frs_seq_fsm #(.PU_CYC(T_PU), .RPH_CYC(T_RPH), .RH_CYC(T_RH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cold_go_i (cold_go),
        .warm_go_i (warm_go),
        .rst_act_i (rst_act),
        .idle_o    (idle),
        .blocked_o (blocked_o),
        .ready_o   (ready_o)
    );

endmodule

// File: rtl/frs_seq_chk.sv
// Module: frs_seq_chk
// Property checker for flash_rst_seq, attached by bind below.
// Assumes: observes ports and the internal start strobes only.
module frs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic blocked_o,
    input logic ready_o,
    input logic cold_go,
    input logic warm_go
);

    // R5: ready lasts a single cycle
    a_r5_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |=> !ready_o);

    // R5: ready only appears in standby
    a_r5_ready_unblocked: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !blocked_o);

    // R2: a cold start blocks on the next cycle with no ready pulse
    a_r2_cold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        cold_go |=> (blocked_o && !ready_o));

    // R6: a qualified pin request blocks on the next cycle
    a_r6_warm_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        warm_go |=> blocked_o);

    // R9: a cold start during a running sequence keeps it blocked
    a_r9_cold_keeps_block: assert property (@(posedge clk) disable iff (!rst_n)
        (cold_go && blocked_o) |=> blocked_o);

    // R10: leaving a sequence is always marked by ready
    a_r10_exit_marked: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blocked_o) |-> ready_o);

    // R7: standby is left only by a start strobe
    a_r7_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!blocked_o && !cold_go && !warm_go) |=> !blocked_o);

endmodule

bind flash_rst_seq frs_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked_o (blocked_o),
    .ready_o   (ready_o),
    .cold_go   (cold_go),
    .warm_go   (warm_go)
);

// File: tb/flash_rst_seq_tb.sv
module flash_rst_seq_tb;

    localparam int T_PD  = 4;
    localparam int T_PU  = 6;
    localparam int T_RP  = 3;
    localparam int T_RPH = 5;
    localparam int T_RH  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0;
    logic pg    = 1'b1;
    logic cs_n  = 1'b1;
    logic io3   = 1'b1;
    logic en    = 1'b0;
    logic quad  = 1'b0;
    logic blocked;
    logic ready;

    flash_rst_seq #(
        .T_PD(T_PD), .T_PU(T_PU), .T_RP(T_RP), .T_RPH(T_RPH), .T_RH(T_RH)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_good_i  (pg),
        .cs_n_i      (cs_n),
        .io3_rst_n_i (io3),
        .hw_rst_en_i (en),
        .quad_mode_i (quad),
        .blocked_o   (blocked),
        .ready_o     (ready)
    );

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R1";
    bit    chk_on = 1'b0;
    bit    done = 1'b0;

    // behavioural reference: mode 0 standby, 1 power-up, 2 pin reset
    int m_mode = 0;
    int m_left = 0;
    int m_rph  = 0;
    int m_rh   = 0;
    int m_run  = 0;
    int m_low  = 0;
    bit m_pgq  = 1'b0;
    bit m_ready = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_left = 0; m_rph = 0; m_rh = 0; m_run = 0;
            m_low = 0; m_pgq = 1'b0; m_ready = 1'b0;
        end else begin
            bit cold_now;
            bit act_now;
            cold_now = pg && !m_pgq && (m_low >= T_PD);
            m_low = pg ? 0 : m_low + 1;
            m_pgq = pg;
            act_now = en && !io3 && (!quad || cs_n);
            m_ready = 1'b0;
            if (cold_now) begin
                m_mode = 1; m_left = T_PU; m_run = 0;
            end else if (m_mode == 0) begin
                m_run = act_now ? m_run + 1 : 0;
                if (m_run >= T_RP) begin
                    m_mode = 2; m_rph = T_RPH; m_rh = T_RH; m_run = 0;
                end
            end else if (m_mode == 1) begin
                m_left = m_left - 1;
                if (m_left == 0) begin m_mode = 0; m_ready = 1'b1; end
            end else begin
                if (m_rph > 0) m_rph = m_rph - 1;
                if (act_now) m_rh = T_RH;
                else if (m_rh > 0) m_rh = m_rh - 1;
                if (m_rph == 0 && m_rh == 0) begin m_mode = 0; m_ready = 1'b1; end
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // episode monitor on the ports
    int run_len = 0;
    int last_len = 0;
    int episodes = 0;
    int ready_cnt = 0;

    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(blocked == (m_mode != 0), cur_req, "blocked vs model",
                  int'(blocked), int'(m_mode != 0));
            check(ready == m_ready, cur_req, "ready vs model",
                  int'(ready), int'(m_ready));
            if (ready) ready_cnt++;
            if (blocked) run_len++;
            else if (run_len > 0) begin
                last_len = run_len; episodes++; run_len = 0;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int ep0;
        int rd0;
        step(3);
        rst_n = 1'b1;
        chk_on = 1'b1;
        step(3);
        // R1: reset state
        check(blocked == 1'b0, "R1", "blocked after reset", int'(blocked), 0);
        check(ready == 1'b0, "R1", "ready after reset", int'(ready), 0);

        // R2: qualified cold start, R5 single ready pulse
        cur_req = "R2";
        pg = 1'b0; step(T_PD); pg = 1'b1;
        step(T_PU + 3);
        check(last_len == T_PU, "R2", "power-up length", last_len, T_PU);
        check(ready_cnt == 1, "R5", "ready pulses", ready_cnt, 1);

        // R3: dip one edge too short
        cur_req = "R3";
        ep0 = episodes;
        pg = 1'b0; step(T_PD - 1); pg = 1'b1;
        step(10);
        check(episodes == ep0, "R3", "episodes after short dip", episodes, ep0);

        // R4: pin activity during power-up is ignored
        cur_req = "R4";
        en = 1'b1;
        pg = 1'b0; step(T_PD); pg = 1'b1; step(1);
        io3 = 1'b0; quad = 1'b1; step(T_PU - 2); io3 = 1'b1; quad = 1'b0;
        step(6);
        check(last_len == T_PU, "R4", "power-up length with pin activity", last_len, T_PU);

        // R6 and R8: minimal pin reset, process time decides the end
        cur_req = "R6";
        ep0 = episodes; rd0 = ready_cnt;
        io3 = 1'b0; step(T_RP); io3 = 1'b1;
        step(T_RPH + 3);
        check(episodes == ep0 + 1, "R6", "warm episode started", episodes, ep0 + 1);
        check(last_len == T_RPH, "R8", "short-hold warm length", last_len, T_RPH);
        check(ready_cnt == rd0 + 1, "R5", "ready after warm", ready_cnt, rd0 + 1);

        // R8: long hold, release hold decides the end
        cur_req = "R8";
        io3 = 1'b0; step(10); io3 = 1'b1;
        step(T_RH + T_RPH + 3);
        check(last_len == 10 - T_RP + T_RH, "R8", "long-hold warm length",
              last_len, 10 - T_RP + T_RH);

        // R7: ignored pin activity
        cur_req = "R7";
        ep0 = episodes;
        io3 = 1'b0; step(T_RP - 1); io3 = 1'b1; step(5);
        check(episodes == ep0, "R7", "short pulse ignored", episodes, ep0);
        io3 = 1'b0; step(2); io3 = 1'b1; step(1); io3 = 1'b0; step(2); io3 = 1'b1; step(5);
        check(episodes == ep0, "R7", "split pulses ignored", episodes, ep0);
        en = 1'b0; io3 = 1'b0; step(8); io3 = 1'b1; en = 1'b1; step(3);
        check(episodes == ep0, "R7", "disabled pin ignored", episodes, ep0);
        quad = 1'b1; cs_n = 1'b0; io3 = 1'b0; step(8);
        check(blocked == 1'b0, "R7", "quad data with cs low ignored", int'(blocked), 0);
        io3 = 1'b1; cs_n = 1'b1; step(3);
        check(episodes == ep0, "R7", "quad data episodes", episodes, ep0);

        // R6: quad mode with chip select high still resets
        cur_req = "R6";
        io3 = 1'b0; step(T_RP); io3 = 1'b1; quad = 1'b0;
        step(T_RPH + 3);
        check(episodes == ep0 + 1, "R6", "quad cs-high reset", episodes, ep0 + 1);

        // R9: cold start during a warm reset takes over
        cur_req = "R9";
        ep0 = episodes; rd0 = ready_cnt;
        io3 = 1'b0; step(T_RP + 1);
        pg = 1'b0; step(T_PD); pg = 1'b1; io3 = 1'b1;
        step(T_PU + T_RPH + 5);
        check(ready_cnt == rd0 + 1, "R9", "single ready across takeover", ready_cnt, rd0 + 1);
        check(episodes == ep0 + 1, "R9", "one merged episode", episodes, ep0 + 1);
        check(last_len == T_PD + T_PU + 2, "R10", "merged blocked length",
              last_len, T_PD + T_PU + 2);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule